// File: doc/BRIEF.md
# Address and Data Breakpoint Trigger Unit

This unit sits next to a CPU pipeline and watches two event streams: the program counter of each executed instruction, and the address, data and address-space identifier of each operand access. It compares them against programmed conditions and raises a one-cycle trigger pulse when a breakpoint condition is met. There are four program-counter comparators and two inclusive operand-address ranges. A range can also require a masked data match on the same access. Either kind of match can also require the current address-space identifier to equal a programmed value.

Triggers run in one of two modes. In single-level mode any enabled comparator fires. In two-level mode a program-counter hit arms the unit, and a later operand-range hit fires it. The configuration registers can only be written. Writes come from an external debug port or from a CPU write path that is accepted only in supervisor mode. Only the status word can be read back. Three registers are shared with debug memory commands, which overwrite them as a side effect.

Top module: `bkpt_trigger_unit`

## Requirements
- R1: After reset, `trig` is low, `status` is zero, and every comparator is disabled, so no program-counter or operand event causes a trigger until the control word enables one.
- R2: Register indices for writes: 0 control, 1 program-counter ASID, 2 data value, 3 data mask, 4 operand attribute (operand ASID in bits 7:0), 5..8 program-counter comparators 0..3, 9/10 range 0 low/high, 11/12 range 1 low/high. Control bits: 3:0 program-counter enables, 5:4 range enables, 7:6 range data-qualify enables, 8 program-counter ASID check, 9 operand ASID check, 10 two-level mode. The registers are write-only. `status` is the only readable state.
- R3: An enabled program-counter comparator hits when `pc_valid` is high and `pc_addr` equals its register. In single-level mode `trig` goes high in the cycle after the event, for exactly one cycle per matching event.
- R4: A range hits when `opd_valid` is high and low ≤ `opd_addr` ≤ high, with both bounds inclusive.
- R5: When data qualification is enabled for a range, that range hits only if the address and the masked data match on the same access. A mask bit of 1 excludes that data bit from the comparison.
- R6: When the ASID checks are enabled, program-counter hits require `cur_asid` to equal register 1, and range hits require it to equal the attribute register.
- R7: Status layout: bit 0 means some trigger has fired, bit 1 means armed, bit 2 is the level of the last trigger (1 means second level), bits 6:3 are the program-counter comparators that caused it, and bits 8:7 are the ranges that caused it.
- R8: In two-level mode a program-counter hit arms the unit. A range hit while armed fires with level 1 and disarms. A range hit while not armed does nothing.
- R9: Any write to the control register clears `trig`, the armed state and the whole status word.
- R10: A debug memory command loads its address into range 0 high and its attributes into the attribute register. A write command also loads its data into the data register. In the same cycle, the memory command takes priority over a register write to that register.
- R11: A debug-port write takes priority over a CPU write in the same cycle. A CPU write with `cpu_wr_sup` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_wr_en | input | 1 | Debug-port register write strobe |
| dbg_wr_addr | input | 4 | Debug-port register index |
| dbg_wr_data | input | 32 | Debug-port write data |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_sup | input | 1 | CPU is in supervisor mode |
| cpu_wr_addr | input | 4 | CPU register index |
| cpu_wr_data | input | 32 | CPU write data |
| mem_cmd_valid | input | 1 | Debug memory command issued |
| mem_cmd_write | input | 1 | Memory command is a write |
| mem_cmd_addr | input | 32 | Memory command address |
| mem_cmd_attr | input | 8 | Memory command bus attributes |
| mem_cmd_data | input | 32 | Memory command write data |
| pc_valid | input | 1 | Instruction executed this cycle |
| pc_addr | input | 32 | Program counter of that instruction |
| cur_asid | input | 8 | Current address-space identifier |
| opd_valid | input | 1 | Operand access this cycle |
| opd_addr | input | 32 | Operand address |
| opd_data | input | 32 | Operand data |
| trig | output | 1 | Breakpoint trigger pulse |
| status | output | 9 | Readable status word |

## Verification
A wrong armed flag or a corrupted comparator register does not show at once. It shows only when a later event should fire and does not, or fires when it should not. The bench therefore follows each reconfiguration, shared-register overwrite and arming step with probing events. The status word shows the armed flag and the cause bits one cycle after the event, so a wrong sequencer state is visible at the port on the next clock.

// File: rtl/bkpt_pkg.sv
// Shared register indices for the breakpoint trigger unit.
// Assumes the comparator registers follow the fixed ones starting at REG_PC_BASE.
package bkpt_pkg;
    localparam int REG_CTRL    = 0;
    localparam int REG_PCASID  = 1;
    localparam int REG_DATA    = 2;
    localparam int REG_DMASK   = 3;
    localparam int REG_ATTR    = 4;
    localparam int REG_PC_BASE = 5;
endpackage

// File: rtl/bkpt_regs.sv
// Write-only breakpoint register file. It picks between the debug port and
// the supervisor CPU write path, and folds in the side effects of debug
// memory commands on the shared registers.
// Assumes IDW <= CW <= W.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int W    = 32,
    parameter int IDW  = 8,
    parameter int NPC  = 4,
    parameter int NRNG = 2,
    parameter int CW   = 11,
    parameter int RA_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dbg_wr_en,
    input  logic [RA_W-1:0]           dbg_wr_addr,
    input  logic [W-1:0]              dbg_wr_data,
    input  logic                      cpu_wr_en,
    input  logic                      cpu_wr_sup,
    input  logic [RA_W-1:0]           cpu_wr_addr,
    input  logic [W-1:0]              cpu_wr_data,
    input  logic                      mem_cmd_valid,
    input  logic                      mem_cmd_write,
    input  logic [W-1:0]              mem_cmd_addr,
    input  logic [IDW-1:0]            mem_cmd_attr,
    input  logic [W-1:0]              mem_cmd_data,
    output logic [CW-1:0]             ctrl,
    output logic [IDW-1:0]            pc_asid,
    output logic [IDW-1:0]            attr,
    output logic [W-1:0]              dval,
    output logic [W-1:0]              dmask,
    output logic [NPC-1:0][W-1:0]     pc_ref,
    output logic [NRNG-1:0][W-1:0]    rng_lo,
    output logic [NRNG-1:0][W-1:0]    rng_hi,
    output logic                      cfg_wr
);
    logic            we;
    logic [RA_W-1:0] wa;
    logic [W-1:0]    wd;

    // Pick the winning write source: the debug port first, then a supervisor CPU write.
    always_comb begin
        we = dbg_wr_en | (cpu_wr_en & cpu_wr_sup);
        wa = dbg_wr_en ? dbg_wr_addr : cpu_wr_addr;
        wd = dbg_wr_en ? dbg_wr_data : cpu_wr_data;
    end

    assign cfg_wr = we && (wa == RA_W'(REG_CTRL));

    // Registers that are not shared with memory commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl    <= '0;
            pc_asid <= '0;
            dmask   <= '0;
        end else if (we) begin
            if (wa == RA_W'(REG_CTRL))   ctrl    <= wd[CW-1:0];
            if (wa == RA_W'(REG_PCASID)) pc_asid <= wd[IDW-1:0];
            if (wa == RA_W'(REG_DMASK))  dmask   <= wd;
        end
    end

    // Shared registers: a memory command overwrites them ahead of a register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr <= '0;
            dval <= '0;
        end else begin
            if (mem_cmd_valid)                      attr <= mem_cmd_attr;
            else if (we && wa == RA_W'(REG_ATTR))   attr <= wd[IDW-1:0];
            if (mem_cmd_valid && mem_cmd_write)     dval <= mem_cmd_data;
            else if (we && wa == RA_W'(REG_DATA))   dval <= wd;
        end
    end

    for (genvar i = 0; i < NPC; i++) begin : g_pc
        localparam logic [RA_W-1:0] IDX = RA_W'(REG_PC_BASE + i);
        // Program-counter comparator value i.
        always_ff @(posedge clk) begin
            if (!rst_n)                pc_ref[i] <= '0;
            else if (we && wa == IDX)  pc_ref[i] <= wd;
        end
    end

    for (genvar r = 0; r < NRNG; r++) begin : g_rng
        localparam logic [RA_W-1:0] LO_IDX = RA_W'(REG_PC_BASE + NPC + 2*r);
        localparam logic [RA_W-1:0] HI_IDX = RA_W'(REG_PC_BASE + NPC + 2*r + 1);
        // Low bound of range r.
        always_ff @(posedge clk) begin
            if (!rst_n)                    rng_lo[r] <= '0;
            else if (we && wa == LO_IDX)   rng_lo[r] <= wd;
        end
        if (r == 0) begin : g_shared
            // The range 0 high bound doubles as the memory command address.
            always_ff @(posedge clk) begin
                if (!rst_n)                    rng_hi[r] <= '0;
                else if (mem_cmd_valid)        rng_hi[r] <= mem_cmd_addr;
                else if (we && wa == HI_IDX)   rng_hi[r] <= wd;
            end
        end else begin : g_private
            // High bound of range r.
            always_ff @(posedge clk) begin
                if (!rst_n)                    rng_hi[r] <= '0;
                else if (we && wa == HI_IDX)   rng_hi[r] <= wd;
            end
        end
    end
endmodule

// File: rtl/bkpt_match.sv
// Combinational comparators: NPC program-counter equality matches and NRNG
// inclusive operand-address ranges, with optional data and ASID qualification.
// Assumes the inputs are stable within the cycle in which the valid flag is high.
module bkpt_match #(
    parameter int W    = 32,
    parameter int IDW  = 8,
    parameter int NPC  = 4,
    parameter int NRNG = 2
) (
    input  logic                      pc_valid,
    input  logic [W-1:0]              pc_addr,
    input  logic                      opd_valid,
    input  logic [W-1:0]              opd_addr,
    input  logic [W-1:0]              opd_data,
    input  logic [IDW-1:0]            cur_asid,
    input  logic [NPC-1:0]            pc_en,
    input  logic [NRNG-1:0]           rng_en,
    input  logic [NRNG-1:0]           rng_dq,
    input  logic                      pc_asid_en,
    input  logic                      opd_asid_en,
    input  logic [IDW-1:0]            pc_asid,
    input  logic [IDW-1:0]            attr,
    input  logic [W-1:0]              dval,
    input  logic [W-1:0]              dmask,
    input  logic [NPC-1:0][W-1:0]     pc_ref,
    input  logic [NRNG-1:0][W-1:0]    rng_lo,
    input  logic [NRNG-1:0][W-1:0]    rng_hi,
    output logic [NPC-1:0]            pc_hit,
    output logic [NRNG-1:0]           rng_hit
);
    logic pc_id_ok, opd_id_ok, data_ok;

    // Shared qualifiers: the ASID checks and the masked data compare.
    always_comb begin
        pc_id_ok  = !pc_asid_en  || (cur_asid == pc_asid);
        opd_id_ok = !opd_asid_en || (cur_asid == attr);
        data_ok   = ((opd_data ^ dval) & ~dmask) == '0;
    end

    for (genvar i = 0; i < NPC; i++) begin : g_pc
        assign pc_hit[i] = pc_en[i] && pc_valid && pc_id_ok && (pc_addr == pc_ref[i]);
    end

    for (genvar r = 0; r < NRNG; r++) begin : g_rng
        assign rng_hit[r] = rng_en[r] && opd_valid && opd_id_ok
                          && (opd_addr >= rng_lo[r]) && (opd_addr <= rng_hi[r])
                          && (!rng_dq[r] || data_ok);
    end
endmodule

// File: rtl/bkpt_seq.sv
// Trigger sequencer: fires on any hit in single-level mode. In two-level mode
// a program-counter hit arms it and a range hit fires it. It also holds the
// status word.
// Assumes the mode changes only through a control write, which clears all state.
module bkpt_seq #(
    parameter int NPC  = 4,
    parameter int NRNG = 2,
    parameter int SW   = 3 + NPC + NRNG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            two_lvl,
    input  logic [NPC-1:0]  pc_hit,
    input  logic [NRNG-1:0] rng_hit,
    output logic            trig,
    output logic [SW-1:0]   status
);
    logic                 fired, armed, lvl;
    logic [NPC+NRNG-1:0]  cause;

    // Advance the arm/fire state and record the cause of each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr) begin
            trig  <= 1'b0;
            fired <= 1'b0;
            armed <= 1'b0;
            lvl   <= 1'b0;
            cause <= '0;
        end else begin
            trig <= 1'b0;
            if (!two_lvl) begin
                if (|{rng_hit, pc_hit}) begin
                    trig  <= 1'b1;
                    fired <= 1'b1;
                    lvl   <= 1'b0;
                    cause <= {rng_hit, pc_hit};
                end
            end else if (armed && |rng_hit) begin
                trig  <= 1'b1;
                fired <= 1'b1;
                lvl   <= 1'b1;
                armed <= 1'b0;
                cause <= {rng_hit, {NPC{1'b0}}};
            end else if (|pc_hit) begin
                armed <= 1'b1;
            end
        end
    end

    assign status = {cause, lvl, armed, fired};
endmodule

// File: rtl/bkpt_trigger_unit.sv
// Top of the breakpoint trigger unit: register file, comparators and sequencer.
// Assumes one program-counter event and one operand event at most per cycle.
module bkpt_trigger_unit #(
    parameter int W    = 32,
    parameter int IDW  = 8,
    parameter int NPC  = 4,
    parameter int NRNG = 2,
    parameter int RA_W = $clog2(5 + NPC + 2*NRNG),
    parameter int SW   = 3 + NPC + NRNG
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_wr_en,
    input  logic [RA_W-1:0] dbg_wr_addr,
    input  logic [W-1:0]    dbg_wr_data,
    input  logic            cpu_wr_en,
    input  logic            cpu_wr_sup,
    input  logic [RA_W-1:0] cpu_wr_addr,
    input  logic [W-1:0]    cpu_wr_data,
    input  logic            mem_cmd_valid,
    input  logic            mem_cmd_write,
    input  logic [W-1:0]    mem_cmd_addr,
    input  logic [IDW-1:0]  mem_cmd_attr,
    input  logic [W-1:0]    mem_cmd_data,
    input  logic            pc_valid,
    input  logic [W-1:0]    pc_addr,
    input  logic [IDW-1:0]  cur_asid,
    input  logic            opd_valid,
    input  logic [W-1:0]    opd_addr,
    input  logic [W-1:0]    opd_data,
    output logic            trig,
    output logic [SW-1:0]   status
);
    localparam int CW = NPC + 2*NRNG + 3;

    logic [CW-1:0]          ctrl;
    logic [IDW-1:0]         pc_asid, attr;
    logic [W-1:0]           dval, dmask;
    logic [NPC-1:0][W-1:0]  pc_ref;
    logic [NRNG-1:0][W-1:0] rng_lo, rng_hi;
    logic                   cfg_wr;
    logic [NPC-1:0]         pc_hit;
    logic [NRNG-1:0]        rng_hit;

    bkpt_regs #(.W(W), .IDW(IDW), .NPC(NPC), .NRNG(NRNG), .CW(CW), .RA_W(RA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_sup(cpu_wr_sup),
        .cpu_wr_addr(cpu_wr_addr), .cpu_wr_data(cpu_wr_data),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_cmd_addr(mem_cmd_addr), .mem_cmd_attr(mem_cmd_attr), .mem_cmd_data(mem_cmd_data),
        .ctrl(ctrl), .pc_asid(pc_asid), .attr(attr), .dval(dval), .dmask(dmask),
        .pc_ref(pc_ref), .rng_lo(rng_lo), .rng_hi(rng_hi), .cfg_wr(cfg_wr)
    );

    bkpt_match #(.W(W), .IDW(IDW), .NPC(NPC), .NRNG(NRNG)) u_match (
        .pc_valid(pc_valid), .pc_addr(pc_addr),
        .opd_valid(opd_valid), .opd_addr(opd_addr), .opd_data(opd_data),
        .cur_asid(cur_asid),
        .pc_en(ctrl[NPC-1:0]),
        .rng_en(ctrl[NPC+NRNG-1:NPC]),
        .rng_dq(ctrl[NPC+2*NRNG-1:NPC+NRNG]),
        .pc_asid_en(ctrl[NPC+2*NRNG]),
        .opd_asid_en(ctrl[NPC+2*NRNG+1]),
        .pc_asid(pc_asid), .attr(attr), .dval(dval), .dmask(dmask),
        .pc_ref(pc_ref), .rng_lo(rng_lo), .rng_hi(rng_hi),
        .pc_hit(pc_hit), .rng_hit(rng_hit)
    );

    bkpt_seq #(.NPC(NPC), .NRNG(NRNG), .SW(SW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .two_lvl(ctrl[NPC+2*NRNG+2]),
        .pc_hit(pc_hit), .rng_hit(rng_hit),
        .trig(trig), .status(status)
    );
endmodule

// File: rtl/bkpt_chk.sv
// Port-level checker for the breakpoint trigger unit, bound to every instance.
// Assumes the status layout {cause, level, armed, fired}.
module bkpt_chk #(
    parameter int RA_W = 4,
    parameter int SW   = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dbg_wr_en,
    input logic [RA_W-1:0] dbg_wr_addr,
    input logic            pc_valid,
    input logic            opd_valid,
    input logic            trig,
    input logic [SW-1:0]   status
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!trig && status == '0));
    assert_no_event_no_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_valid && !opd_valid) |=> !trig);
    assert_trig_marks_fired_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> status[0]);
    assert_second_needs_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && status[2]) |-> ($past(status[1]) && !status[1]));
    assert_cfg_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr_en && dbg_wr_addr == '0) |=> (!trig && status == '0));
endmodule

bind bkpt_trigger_unit bkpt_chk #(.RA_W(RA_W), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr),
    .pc_valid(pc_valid), .opd_valid(opd_valid), .trig(trig), .status(status)
);

// File: tb/tb_bkpt_trigger_unit.sv
module tb_bkpt_trigger_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_wr_en = 0, cpu_wr_en = 0, cpu_wr_sup = 0;
    logic [3:0]  dbg_wr_addr = 0, cpu_wr_addr = 0;
    logic [31:0] dbg_wr_data = 0, cpu_wr_data = 0;
    logic        mem_cmd_valid = 0, mem_cmd_write = 0;
    logic [31:0] mem_cmd_addr = 0, mem_cmd_data = 0;
    logic [7:0]  mem_cmd_attr = 0, cur_asid = 0;
    logic        pc_valid = 0, opd_valid = 0;
    logic [31:0] pc_addr = 0, opd_addr = 0, opd_data = 0;
    logic        trig;
    logic [8:0]  status;

    bkpt_trigger_unit dut (.*);

    always #2 clk = ~clk;

    // Behavioural reference state.
    logic [31:0] m_reg [16];
    bit          m_trig, m_fired, m_armed, m_lvl;
    bit [5:0]    m_cause;
    int          n_vec = 0, n_bad = 0;
    string       cur_req = "R1";

    function automatic void model_step();
        bit [3:0] ph; bit [1:0] rh; logic [31:0] c;
        bit we; int wa; logic [31:0] wd;
        c = m_reg[0];
        for (int i = 0; i < 4; i++)
            ph[i] = c[i] && pc_valid && pc_addr == m_reg[5+i] &&
                    (!c[8] || cur_asid == m_reg[1][7:0]);
        for (int r = 0; r < 2; r++)
            rh[r] = c[4+r] && opd_valid && opd_addr >= m_reg[9+2*r] && opd_addr <= m_reg[10+2*r] &&
                    (!c[9] || cur_asid == m_reg[4][7:0]) &&
                    (!c[6+r] || ((opd_data ^ m_reg[2]) & ~m_reg[3]) == 0);
        we = dbg_wr_en || (cpu_wr_en && cpu_wr_sup);
        wa = dbg_wr_en ? int'(dbg_wr_addr) : int'(cpu_wr_addr);
        wd = dbg_wr_en ? dbg_wr_data : cpu_wr_data;
        m_trig = 0;
        if (we && wa == 0) begin
            m_fired = 0; m_armed = 0; m_lvl = 0; m_cause = 0;
        end else if (!c[10]) begin
            if (ph != 0 || rh != 0) begin
                m_trig = 1; m_fired = 1; m_lvl = 0; m_cause = {rh, ph};
            end
        end else if (m_armed && rh != 0) begin
            m_trig = 1; m_fired = 1; m_lvl = 1; m_armed = 0; m_cause = {rh, 4'b0};
        end else if (ph != 0) m_armed = 1;
        if (we) m_reg[wa] = (wa == 0) ? (wd & 32'h7FF) : ((wa == 1 || wa == 4) ? (wd & 32'hFF) : wd);
        if (mem_cmd_valid) begin
            m_reg[10] = mem_cmd_addr;
            m_reg[4]  = {24'b0, mem_cmd_attr};
            if (mem_cmd_write) m_reg[2] = mem_cmd_data;
        end
    endfunction

    task automatic idle_inputs();
        dbg_wr_en = 0; cpu_wr_en = 0; cpu_wr_sup = 0; mem_cmd_valid = 0;
        mem_cmd_write = 0; pc_valid = 0; opd_valid = 0;
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        n_vec++;
        if (trig !== m_trig || status !== {m_cause, m_lvl, m_armed, m_fired}) begin
            n_bad++;
            $display("FAIL %s: trig=%b status=%h expected trig=%b status=%h", cur_req,
                     trig, status, m_trig, {m_cause, m_lvl, m_armed, m_fired});
        end
        idle_inputs();
    endtask

    task automatic dwr(input int a, input logic [31:0] d);
        dbg_wr_en = 1; dbg_wr_addr = 4'(a); dbg_wr_data = d; cycle();
    endtask
    task automatic cwr(input int a, input logic [31:0] d, input bit sup);
        cpu_wr_en = 1; cpu_wr_sup = sup; cpu_wr_addr = 4'(a); cpu_wr_data = d; cycle();
    endtask
    task automatic pce(input logic [31:0] a, input logic [7:0] id);
        pc_valid = 1; pc_addr = a; cur_asid = id; cycle();
    endtask
    task automatic ope(input logic [31:0] a, input logic [31:0] d, input logic [7:0] id);
        opd_valid = 1; opd_addr = a; opd_data = d; cur_asid = id; cycle();
    endtask
    task automatic mcmd(input bit w, input logic [31:0] a, input logic [7:0] at, input logic [31:0] d);
        mem_cmd_valid = 1; mem_cmd_write = w; mem_cmd_addr = a; mem_cmd_attr = at;
        mem_cmd_data = d; cycle();
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m_reg[i] = 0;
        m_trig = 0; m_fired = 0; m_armed = 0; m_lvl = 0; m_cause = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state and all comparators disabled
        cur_req = "R1"; cycle(); pce(0, 0); ope(0, 0, 0); cycle();
        // R3: program-counter comparator 1, single level, one pulse per event
        cur_req = "R3"; dwr(6, 32'h1000); dwr(0, 32'h002); pce(32'h1000, 0); cycle();
        pce(32'h1004, 0); pce(32'h1000, 0); pce(32'h1000, 0); cycle();
        // R2/R7: several comparators together, cause bits
        cur_req = "R7"; dwr(8, 32'h1000); dwr(0, 32'h00A); pce(32'h1000, 0); cycle();
        // R6: program-counter ASID check
        cur_req = "R6"; dwr(1, 32'h3C); dwr(0, 32'h102); pce(32'h1000, 8'h3B); pce(32'h1000, 8'h3C);
        // R4: inclusive range 0
        cur_req = "R4"; dwr(9, 100); dwr(10, 200); dwr(0, 32'h010);
        ope(99, 0, 0); ope(100, 0, 0); ope(150, 0, 0); ope(200, 0, 0); ope(201, 0, 0);
        // R5: masked data on range 1
        cur_req = "R5"; dwr(11, 32'h500); dwr(12, 32'h5FF); dwr(2, 32'hA5A5_0000);
        dwr(3, 32'h0000_FFFF); dwr(0, 32'h0A0);
        ope(32'h500, 32'hA5A5_1234, 0); ope(32'h500, 32'hA5A4_0000, 0); ope(32'h4FF, 32'hA5A5_0000, 0);
        ope(32'h5FF, 32'hA5A5_FFFF, 0);
        // R6: operand ASID check through attribute register
        cur_req = "R6"; dwr(4, 32'h11); dwr(0, 32'h210); ope(150, 0, 8'h12); ope(150, 0, 8'h11);
        // R8: two-level sequence
        cur_req = "R8"; dwr(0, 32'h412); ope(150, 0, 0); pce(32'h1000, 0); cycle();
        pce(32'h1000, 0); ope(150, 0, 0); ope(150, 0, 0); cycle();
        // R9: control write clears armed state
        cur_req = "R9"; pce(32'h1000, 0); dwr(0, 32'h412); ope(150, 0, 0);
        // R10: shared registers overwritten by memory commands
        cur_req = "R10"; dwr(0, 32'h010); ope(250, 0, 0); mcmd(0, 300, 8'h11, 0); ope(250, 0, 0);
        dwr(0, 32'h210); ope(250, 0, 8'h11); mcmd(0, 300, 8'h22, 0); ope(250, 0, 8'h11); ope(250, 0, 8'h22);
        dwr(0, 32'h0A0); ope(32'h500, 32'hA5A5_0000, 0);
        mcmd(1, 300, 0, 32'h1234_0000); ope(32'h500, 32'hA5A5_0000, 0); ope(32'h500, 32'h1234_9999, 0);
        dwr(0, 32'h010);
        dbg_wr_en = 1; dbg_wr_addr = 4'd10; dbg_wr_data = 32'd120;
        mem_cmd_valid = 1; mem_cmd_addr = 32'd400; cycle();
        ope(350, 0, 0);
        // R11: CPU writes need supervisor mode; debug port wins a collision
        cur_req = "R11"; cwr(0, 32'h002, 0); pce(32'h1000, 0); ope(150, 0, 0);
        cwr(6, 32'h2000, 1); cwr(0, 32'h002, 1); pce(32'h2000, 0);
        dbg_wr_en = 1; dbg_wr_addr = 4'd6; dbg_wr_data = 32'h3000;
        cpu_wr_en = 1; cpu_wr_sup = 1; cpu_wr_addr = 4'd6; cpu_wr_data = 32'h4000; cycle();
        pce(32'h4000, 0); pce(32'h3000, 0); cycle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule